// File: doc/BRIEF.md
# GPIO Bank Controller with Peripheral Muxing

This block runs one bank of general-purpose pins from a small word-addressed register bus. Each pin is either kept by the GPIO logic or handed to one of two on-chip peripheral functions, called function A and function B. The block drives the pad's output value, its output enable and its pull-up request. An open-drain option turns any driven output into a "drive low or release" output. On the input side each pad is resynchronised and can pass through an optional glitch filter. Any change of level, rising or falling, marks that pin as pending.

Software never does a read-modify-write on a setting. Every setting has a set address and a clear address. A 1 in the written word changes that pin and a 0 leaves it alone. A third address reads the setting back. The pending flags are read at a status address, and that read also clears them. The bank interrupt line is high while any pending flag is also enabled in the interrupt mask.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every pin is owned by GPIO and the pull-up is on for every pin. All other settings are 0, no flag is pending and `bank_irq` is low.
- R2: Setting k (0 GPIO ownership, 1 output enable, 2 output data, 3 pull-up, 4 open-drain, 5 glitch filter, 6 interrupt mask, 7 function-B select) has three word addresses. A write to 4k sets the pins whose bits are 1. A write to 4k+1 clears those pins. A read of 4k+2 returns the setting. Bits written as 0 change nothing.
- R3: A GPIO-owned pin without open-drain drives `pad_out` from its output-data bit and `pad_oe` from its output-enable bit.
- R4: On a pin not owned by GPIO, output value and enable come from function A when the select bit is 0 and from function B when it is 1. `pfa_in`/`pfb_in` show the pad level only on pins routed to that function and read 0 elsewhere.
- R5: With open-drain set, a pin whose selected source drives 1 or is disabled has `pad_oe` 0. A pin whose source drives 0 has `pad_oe` 1. `pad_out` is always 0.
- R6: Address 0x20 returns the pad levels after a two-flop synchronizer, whatever the ownership. A change before clock edge 1 is visible after edge 2.
- R7: With the filter off, a rising or falling pad change before edge 1 sets the pin's flag at address 0x21 after edge 3. Reading 0x21 without the bus select does not clear it.
- R8: A selected read of 0x21 returns the pending flags and clears them at that edge. A change flagged at the same edge stays pending.
- R9: `bank_irq` is the OR of the pending flags ANDed with the mask. Flags set on masked pins too.
- R10: With the filter on, a pad pulse seen at only one clock edge sets no flag, while a held change still does. With the filter off, the same pulse sets a flag.
- R11: `pad_pull_en` equals the pull-up setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pull_en | output | 32 | Pull-up requests |
| pfa_out | input | 32 | Function A output values |
| pfa_oe | input | 32 | Function A output enables |
| pfa_in | output | 32 | Pad levels toward function A |
| pfb_out | input | 32 | Function B output values |
| pfb_oe | input | 32 | Function B output enables |
| pfb_in | output | 32 | Pad levels toward function B |
| bank_irq | output | 1 | Combined bank interrupt |

## Verification
A setting register that loses or gains a bit shows up at the pad outputs in the same cycle the write lands. It also shows up on the next read-back of that setting. A broken input path or pending register shows up at the status address within three edges of a pad change. A status read that drops a flag shows up as a missing bit, and a broken filter shows up as a single-edge pulse that is kept or a held change that is lost. A wrong interrupt gate shows at `bank_irq` in the cycle the mask or pending flag changes.

// File: rtl/gpio_bank_pkg.sv
// Shared constants for the GPIO bank: setting indices and the address map.
// Assumes a 6-bit word address; setting k owns addresses 4k, 4k+1, 4k+2.
package gpio_bank_pkg;
    localparam int ADDR_W    = 6;
    localparam int NUM_CFG   = 8;
    localparam int CFG_OWN   = 0;
    localparam int CFG_OE    = 1;
    localparam int CFG_DOUT  = 2;
    localparam int CFG_PULL  = 3;
    localparam int CFG_OD    = 4;
    localparam int CFG_FILT  = 5;
    localparam int CFG_MASK  = 6;
    localparam int CFG_SELB  = 7;
    localparam int KIND_SET  = 0;
    localparam int KIND_CLR  = 1;
    localparam int KIND_READ = 2;
    localparam logic [ADDR_W-1:0] ADDR_LEVEL  = 6'h20;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 6'h21;

    // Word address of one access kind of one setting.
    function automatic logic [ADDR_W-1:0] cfg_addr(input int idx, input int kind);
        logic [31:0] full;
        full = 32'(idx * 4 + kind);
        return full[ADDR_W-1:0];
    endfunction
endpackage

// File: rtl/gpio_setclr_reg.sv
// One per-pin setting vector changed only by set and clear masks.
// Assumes set and clear are not both 1 for one bit; if they are, clear wins.
module gpio_setclr_reg #(
    parameter int W = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] q
);
    // Apply the set mask, then the clear mask; hold bits that are 0 in both.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= (q | set_mask) & ~clr_mask;
    end
endmodule

// File: rtl/gpio_in_cond.sv
// Input path: two-flop synchronizer, optional two-sample agreement filter,
// and detection of any level change on the selected level.
// Assumes pad_in is asynchronous and held at 0 while reset is active.
module gpio_in_cond #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] filt_en,
    output logic [W-1:0] lvl_sync,
    output logic [W-1:0] change
);
    logic [W-1:0] sync1_q, sync2_q, samp_q, filt_q, prev_q;
    logic [W-1:0] agree, sel_lvl;

    // A filtered bit may move only when two samples in a row agree.
    assign agree   = ~(sync2_q ^ samp_q);
    assign sel_lvl = (filt_en & filt_q) | (~filt_en & sync2_q);

    // Synchronize, filter and remember the previous selected level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            samp_q  <= '0;
            filt_q  <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= pad_in;
            sync2_q <= sync1_q;
            samp_q  <= sync2_q;
            filt_q  <= (agree & sync2_q) | (~agree & filt_q);
            prev_q  <= sel_lvl;
        end
    end

    assign lvl_sync = sync2_q;
    assign change   = sel_lvl ^ prev_q;
endmodule

// File: rtl/gpio_pin_mux.sv
// Combinational pin routing: picks the GPIO, function A or function B drive
// for each pin, applies open-drain, and gates the pad level to the functions.
// Assumes all inputs are per-pin vectors of equal width.
module gpio_pin_mux #(
    parameter int W = 32
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] selb,
    input  logic [W-1:0] oe,
    input  logic [W-1:0] dout,
    input  logic [W-1:0] od,
    input  logic [W-1:0] pfa_out,
    input  logic [W-1:0] pfa_oe,
    input  logic [W-1:0] pfb_out,
    input  logic [W-1:0] pfb_oe,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pfa_in,
    output logic [W-1:0] pfb_in
);
    logic [W-1:0] src_out, src_oe, to_a, to_b;

    // Choose the drive source of every pin and apply open-drain.
    always_comb begin
        to_a    = ~own & ~selb;
        to_b    = ~own & selb;
        src_out = (own & dout) | (to_a & pfa_out) | (to_b & pfb_out);
        src_oe  = (own & oe)   | (to_a & pfa_oe)  | (to_b & pfb_oe);
        pad_out = src_out & ~od;
        pad_oe  = src_oe & (~od | ~src_out);
        pfa_in  = pad_in & to_a;
        pfb_in  = pad_in & to_b;
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
// GPIO bank top: register decode, eight set/clear settings, input
// conditioning, pending flags cleared on read, and the bank interrupt.
// Assumes one bus access per cycle; read data is combinational from address.
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_pull_en,
    input  logic [PINS-1:0]   pfa_out,
    input  logic [PINS-1:0]   pfa_oe,
    output logic [PINS-1:0]   pfa_in,
    input  logic [PINS-1:0]   pfb_out,
    input  logic [PINS-1:0]   pfb_oe,
    output logic [PINS-1:0]   pfb_in,
    output logic              bank_irq
);
    logic [NUM_CFG-1:0][PINS-1:0] cfg_q;
    logic [NUM_CFG-1:0][PINS-1:0] set_m, clr_m;
    logic [PINS-1:0] own_q, oe_q, dout_q, od_q, filt_q, mask_q, selb_q;
    logic [PINS-1:0] lvl, chg, pend_q;
    logic            rd_stat;

    // One set/clear register per setting; ownership and pull-up reset to 1.
    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        localparam logic [PINS-1:0] RV = (k == CFG_OWN || k == CFG_PULL) ? '1 : '0;
        assign set_m[k] = (bus_sel && bus_wr && bus_addr == cfg_addr(k, KIND_SET)) ? bus_wdata : '0;
        assign clr_m[k] = (bus_sel && bus_wr && bus_addr == cfg_addr(k, KIND_CLR)) ? bus_wdata : '0;
        gpio_setclr_reg #(.W(PINS), .RST_VAL(RV)) u_reg (
            .clk(clk), .rst_n(rst_n),
            .set_mask(set_m[k]), .clr_mask(clr_m[k]), .q(cfg_q[k])
        );
    end

    assign own_q       = cfg_q[CFG_OWN];
    assign oe_q        = cfg_q[CFG_OE];
    assign dout_q      = cfg_q[CFG_DOUT];
    assign od_q        = cfg_q[CFG_OD];
    assign filt_q      = cfg_q[CFG_FILT];
    assign mask_q      = cfg_q[CFG_MASK];
    assign selb_q      = cfg_q[CFG_SELB];
    assign pad_pull_en = cfg_q[CFG_PULL];

    gpio_in_cond #(.W(PINS)) u_in (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .filt_en(filt_q),
        .lvl_sync(lvl), .change(chg)
    );

    gpio_pin_mux #(.W(PINS)) u_mux (
        .own(own_q), .selb(selb_q), .oe(oe_q), .dout(dout_q), .od(od_q),
        .pfa_out(pfa_out), .pfa_oe(pfa_oe), .pfb_out(pfb_out), .pfb_oe(pfb_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pfa_in(pfa_in), .pfb_in(pfb_in)
    );

    assign rd_stat = bus_sel && !bus_wr && bus_addr == ADDR_STATUS;

    // Pending flags: a status read clears them, and new changes are ORed in last.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (rd_stat ? '0 : pend_q) | chg;
    end

    assign bank_irq = |(pend_q & mask_q);

    // Read multiplexer over the setting read-backs, pad levels and status.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_LEVEL)
            bus_rdata = lvl;
        else if (bus_addr == ADDR_STATUS)
            bus_rdata = pend_q;
        else if (!bus_addr[5] && bus_addr[1:0] == 2'd2)
            bus_rdata = cfg_q[bus_addr[4:2]];
    end
endmodule

// File: rtl/gpio_bank_chk.sv
// Assertion checker for gpio_bank_ctrl, attached with bind below.
// Assumes the internal setting and pending vectors named in the bind.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic              bank_irq,
    input logic [PINS-1:0]   own_q,
    input logic [PINS-1:0]   oe_q,
    input logic [PINS-1:0]   od_q,
    input logic [PINS-1:0]   mask_q,
    input logic [PINS-1:0]   pend_q,
    input logic [PINS-1:0]   chg
);
    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == cfg_addr(CFG_MASK, KIND_SET))
        |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_oe_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == cfg_addr(CFG_OE, KIND_CLR))
        |=> ((oe_q & $past(bus_wdata)) == '0));

    assert_gpio_undriven_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & own_q & ~oe_q) == '0));

    assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & od_q) == '0));

    assert_change_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chg != '0) |=> ((pend_q & $past(chg)) == $past(chg)));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == ADDR_STATUS) |=> (pend_q == $past(chg)));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !bank_irq);
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.PINS(PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_out(pad_out),
    .pad_oe(pad_oe), .bank_irq(bank_irq), .own_q(own_q), .oe_q(oe_q),
    .od_q(od_q), .mask_q(mask_q), .pend_q(pend_q), .chg(chg)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pull_en;
    logic [31:0] pfa_out = '0, pfa_oe = '0, pfa_in, pfb_out = '0, pfb_oe = '0, pfb_in;
    logic        bank_irq;
    int          checks = 0, errors = 0;
    logic [31:0] exp_cfg [8];
    logic [31:0] rd;

    gpio_bank_ctrl u_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pfa_out(pfa_out), .pfa_oe(pfa_oe),
        .pfa_in(pfa_in), .pfb_out(pfb_out), .pfb_oe(pfb_oe), .pfb_in(pfb_in),
        .bank_irq(bank_irq)
    );

    always #4 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic peek(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Expected pad drive from the model, following R3, R4 and R5.
    function automatic logic [31:0] src_out_f();
        return (exp_cfg[0] & exp_cfg[2]) | (~exp_cfg[0] & ~exp_cfg[7] & pfa_out)
             | (~exp_cfg[0] & exp_cfg[7] & pfb_out);
    endfunction
    function automatic logic [31:0] src_oe_f();
        return (exp_cfg[0] & exp_cfg[1]) | (~exp_cfg[0] & ~exp_cfg[7] & pfa_oe)
             | (~exp_cfg[0] & exp_cfg[7] & pfb_oe);
    endfunction

    task automatic check_pins();
        logic [31:0] so, se;
        so = src_out_f();
        se = src_oe_f();
        check("R3/R4/R5 pad_out", pad_out, so & ~exp_cfg[4]);
        check("R3/R4/R5 pad_oe", pad_oe, se & (~exp_cfg[4] | ~so));
        check("R4 pfa_in", pfa_in, pad_in & ~exp_cfg[0] & ~exp_cfg[7]);
        check("R4 pfb_in", pfb_in, pad_in & ~exp_cfg[0] & exp_cfg[7]);
        check("R11 pull", pad_pull_en, exp_cfg[3]);
    endtask

    task automatic settle_clear();
        repeat (8) @(posedge clk);
        bus_read(6'h21, rd);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed);
        for (int k = 0; k < 8; k++) exp_cfg[k] = (k == 0 || k == 3) ? '1 : '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int k = 0; k < 8; k++) begin
            peek(6'(k * 4 + 2), rd);
            check("R1 reset setting", rd, exp_cfg[k]);
        end
        peek(6'h21, rd);
        check("R1 reset pending", rd, 32'h0);
        check("R1 reset irq", {31'b0, bank_irq}, 32'h0);

        // R2 random set/clear writes, read-back and pin routing
        for (int i = 0; i < 300; i++) begin
            int k;
            logic [31:0] d;
            bit clr;
            k = int'($urandom % 8);
            clr = bit'($urandom % 2);
            d = $urandom;
            bus_write(6'(k * 4 + (clr ? 1 : 0)), d);
            exp_cfg[k] = clr ? (exp_cfg[k] & ~d) : (exp_cfg[k] | d);
            peek(6'(k * 4 + 2), rd);
            check("R2 readback", rd, exp_cfg[k]);
            pfa_out = $urandom; pfa_oe = $urandom;
            pfb_out = $urandom; pfb_oe = $urandom;
            pad_in = $urandom;
            #1 check_pins();
        end

        // Directed open-drain corner (R5): GPIO drives 0 and 1 on bits 0/1
        bus_write(6'h00, 32'h3); exp_cfg[0] |= 32'h3;
        bus_write(6'h04, 32'h3); exp_cfg[1] |= 32'h3;
        bus_write(6'h08, 32'h2); exp_cfg[2] |= 32'h2;
        bus_write(6'h09, 32'h1); exp_cfg[2] &= ~32'h1;
        bus_write(6'h10, 32'h3); exp_cfg[4] |= 32'h3;
        check("R5 od bits", {30'b0, pad_oe[1:0]}, 32'h1);
        check("R5 od out", {30'b0, pad_out[1:0]}, 32'h0);

        // Restore a quiet configuration for the input tests
        bus_write(6'h00, '1); exp_cfg[0] = '1;
        bus_write(6'h05, '1); exp_cfg[1] = '0;
        bus_write(6'h11, '1); exp_cfg[4] = '0;
        bus_write(6'h15, '1); exp_cfg[5] = '0;
        bus_write(6'h19, '1); exp_cfg[6] = '0;
        @(negedge clk) pad_in = '0;
        settle_clear();
        peek(6'h21, rd);
        check("R8 cleared", rd, 32'h0);

        // R6 and R7 latency of a rising change on bit 3
        @(negedge clk) begin pad_in[3] = 1'b1; bus_addr = 6'h20; end
        @(posedge clk); #1 check("R6 level after 1 edge", bus_rdata, 32'h0);
        @(posedge clk); #1 check("R6 level after 2 edges", bus_rdata, 32'h8);
        peek(6'h21, rd);
        check("R7 pending after 2 edges", rd, 32'h0);
        @(posedge clk); #1 check("R7 pending after 3 edges", bus_rdata, 32'h8);
        bus_read(6'h21, rd);
        check("R8 read returns", rd, 32'h8);
        peek(6'h21, rd);
        check("R8 read cleared", rd, 32'h0);
        // R7 falling change
        @(negedge clk) pad_in[3] = 1'b0;
        repeat (4) @(posedge clk);
        peek(6'h21, rd);
        check("R7 falling edge", rd, 32'h8);
        bus_read(6'h21, rd);

        // R8 change in the same cycle as the status read
        @(negedge clk) pad_in[4] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) begin bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h21; end
        #1 check("R8 read before change", bus_rdata, 32'h0);
        @(negedge clk) bus_sel = 1'b0;
        #1 check("R8 change kept", bus_rdata, 32'h10);
        bus_read(6'h21, rd);

        // R9 masked pending then unmask
        @(negedge clk) pad_in[7] = 1'b1;
        repeat (5) @(posedge clk);
        #1 check("R9 masked irq low", {31'b0, bank_irq}, 32'h0);
        peek(6'h21, rd);
        check("R9 pending while masked", rd, 32'h80);
        bus_write(6'h18, 32'h80); exp_cfg[6] |= 32'h80;
        check("R9 irq high", {31'b0, bank_irq}, 32'h1);
        bus_read(6'h21, rd);
        check("R9 irq after clear", {31'b0, bank_irq}, 32'h0);

        // R10 glitch filter on bit 5
        bus_write(6'h14, 32'h20); exp_cfg[5] |= 32'h20;
        settle_clear();
        @(negedge clk) pad_in[5] = 1'b1;
        @(negedge clk) pad_in[5] = 1'b0;
        repeat (10) @(posedge clk);
        peek(6'h21, rd);
        check("R10 pulse filtered", rd, 32'h0);
        @(negedge clk) pad_in[5] = 1'b1;
        repeat (10) @(posedge clk);
        peek(6'h21, rd);
        check("R10 held change passes", rd, 32'h20);
        @(negedge clk) pad_in[5] = 1'b0;
        settle_clear();
        bus_write(6'h15, 32'h20); exp_cfg[5] &= ~32'h20;
        settle_clear();
        @(negedge clk) pad_in[5] = 1'b1;
        @(negedge clk) pad_in[5] = 1'b0;
        repeat (10) @(posedge clk);
        peek(6'h21, rd);
        check("R10 pulse unfiltered", rd, 32'h20);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule